// File: doc/BRIEF.md
# Carry-Save Arithmetic Logic Unit

This block is a sixteen-bit arithmetic and logic unit with registered outputs. Each cycle it takes two operands, a four-bit operation code and a product word supplied by a separate multiplier. One clock edge later it presents a 32-bit result, a carry flag and a zero flag. The unit does not stall and has no handshake. A new operation can be issued every cycle, and the outputs always show the operation that was sampled at the previous edge.

Addition, subtraction, increment and decrement all use one datapath. The unit picks a second operand and a constant, then compresses the three words into a sum word and a carry word, with no carry moving between bit positions. One carry-propagate addition then forms the final value. Subtraction adds the inverted second operand plus one. Decrement adds a word of all ones. Shifts, bitwise operations and the multiply pass-through do not use the adder.

Top module: `alu16_csa`

## Requirements
- R1: All outputs are registered and show the operation sampled at the previous rising edge. While the synchronous active-high reset is held, the result is 0, the carry flag is 0 and the zero flag is 1.
- R2: Opcode 0 (add) gives (A + B) mod 2^16 in result bits 15:0. The carry flag is bit 16 of A + B.
- R3: Opcode 1 (subtract) gives (A - B) mod 2^16. The carry flag is 1 exactly when A >= B, meaning no borrow.
- R4: Opcode 2 (increment) gives (A + 1) mod 2^16. The carry flag is 1 only when A = 0xFFFF.
- R5: Opcode 3 (decrement) gives (A - 1) mod 2^16. The carry flag is 1 unless A = 0.
- R6: Opcode 4 shifts A left by one place and fills with 0. The bit shifted out (A bit 15) appears on the carry flag.
- R7: Opcode 5 shifts A right by one place and fills with 0. The bit shifted out (A bit 0) appears on the carry flag.
- R8: Opcode 6 passes the 32-bit product input to the result unchanged. The carry flag is 0.
- R9: Opcodes 7, 8, 9 and 10 give A AND B, A OR B, NOT A and A XOR B respectively. The carry flag is 0.
- R10: Opcodes 11 to 15 give a result of 0 and a carry flag of 0.
- R11: The zero flag is 1 exactly when all 32 result bits are 0.
- R12: Opcodes 0 to 5, 7, 8, 9 and 10 leave result bits 31:16 at 0. Every add-type value equals the sum word plus twice the carry word of a three-input carry-save stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| opcode | input | 4 | Operation select, 0 to 15 |
| mul_product | input | 32 | Product word from an external multiplier |
| result | output | 32 | Registered result |
| carry_flag | output | 1 | Registered carry or shifted-out bit |
| zero_flag | output | 1 | Registered flag, high when the result is zero |

## Verification
A fault in operand selection, such as a dropped inversion or a misplaced constant, gives a wrong sum and a wrong carry flag. These show at the ports one edge after the opcode is sampled. Nothing is retained between operations, so a bad compression or a bad carry-word shift affects only the one cycle in which it happens. The stimulus therefore covers carry-chain extremes: all ones plus one, zero minus one, equal operands on subtract and zero results, each of which exercises the full carry path. Random operands under every opcode, including the unused ones, check the flags and the upper result half on every sample.

// File: rtl/alu_csa_pkg.sv
package alu_csa_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_SHL = 4'd4,
    OP_SHR = 4'd5,
    OP_MUL = 4'd6,
    OP_AND = 4'd7,
    OP_OR  = 4'd8,
    OP_NOT = 4'd9,
    OP_XOR = 4'd10
  } alu_op_e;

  function automatic logic is_add_type(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
  endfunction

endpackage

// File: rtl/csa_compress.sv
module csa_compress #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] z_in,
  output logic [W-1:0] sum_w,
  output logic [W-1:0] cry_w
);

  localparam int CW = W + 2;

  // independent 3:2 cell per bit position, no carry moves sideways
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum_w[i] = x_in[i] ^ y_in[i] ^ z_in[i];
    assign cry_w[i] = (x_in[i] & y_in[i]) | (x_in[i] & z_in[i]) | (y_in[i] & z_in[i]);
  end

  logic [CW-1:0] lhs_chk, rhs_chk;
  always_comb begin
    lhs_chk = CW'(sum_w) + (CW'(cry_w) << 1);
    rhs_chk = CW'(x_in) + CW'(y_in) + CW'(z_in);
    // R12: compressed pair must carry the full three-input total
    assert_csa_sum_R12: assert (lhs_chk == rhs_chk);
  end

endmodule

// File: rtl/cpa_final.sv
module cpa_final #(
  parameter int W = 16
) (
  input  logic [W-1:0] sum_w,
  input  logic [W-1:0] cry_w,
  output logic [W:0]   total
);

  // carry word weighs one position higher than the sum word
  assign total = {1'b0, sum_w} + {cry_w, 1'b0};

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_csa_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W:0]   total
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] y_sel, z_sel;
  logic [W-1:0] s_w, c_w;

  always_comb begin
    unique case (op)
      OP_SUB:  begin y_sel = ~b_in; z_sel = ONE;  end
      OP_INC:  begin y_sel = ZERO;  z_sel = ONE;  end
      OP_DEC:  begin y_sel = ONES;  z_sel = ZERO; end
      default: begin y_sel = b_in;  z_sel = ZERO; end
    endcase
  end

  csa_compress #(.W(W)) u_csa (
    .x_in  (a_in),
    .y_in  (y_sel),
    .z_in  (z_sel),
    .sum_w (s_w),
    .cry_w (c_w)
  );

  cpa_final #(.W(W)) u_cpa (
    .sum_w (s_w),
    .cry_w (c_w),
    .total (total)
  );

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_csa_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] res,
  output logic         shift_out
);

  always_comb begin
    shift_out = 1'b0;
    unique case (op)
      OP_SHL:  begin res = {a_in[W-2:0], 1'b0}; shift_out = a_in[W-1]; end
      OP_SHR:  begin res = {1'b0, a_in[W-1:1]}; shift_out = a_in[0];   end
      OP_AND:  res = a_in & b_in;
      OP_OR:   res = a_in | b_in;
      OP_NOT:  res = ~a_in;
      OP_XOR:  res = a_in ^ b_in;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu16_csa.sv
module alu16_csa
  import alu_csa_pkg::*;
#(
  parameter int W = 16,
  localparam int RW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [3:0]    opcode,
  input  logic [RW-1:0] mul_product,
  output logic [RW-1:0] result,
  output logic          carry_flag,
  output logic          zero_flag
);

  localparam logic [RW-W-1:0] UPPER_ZERO = '0;

  alu_op_e       op_e;
  logic [W:0]    arith_total;
  logic [W-1:0]  bit_res;
  logic          bit_carry;
  logic [RW-1:0] nxt_res;
  logic          nxt_carry;

  assign op_e = alu_op_e'(opcode);

  alu_arith #(.W(W)) u_arith (
    .op    (op_e),
    .a_in  (op_a),
    .b_in  (op_b),
    .total (arith_total)
  );

  alu_bitops #(.W(W)) u_bits (
    .op        (op_e),
    .a_in      (op_a),
    .b_in      (op_b),
    .res       (bit_res),
    .shift_out (bit_carry)
  );

  always_comb begin
    if (is_add_type(op_e)) begin
      nxt_res   = {UPPER_ZERO, arith_total[W-1:0]};
      nxt_carry = arith_total[W];
    end else if (op_e == OP_MUL) begin
      nxt_res   = mul_product;
      nxt_carry = 1'b0;
    end else begin
      nxt_res   = {UPPER_ZERO, bit_res};
      nxt_carry = bit_carry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      carry_flag <= 1'b0;
      zero_flag  <= 1'b1;
    end else begin
      result     <= nxt_res;
      carry_flag <= nxt_carry;
      zero_flag  <= (nxt_res == '0);
    end
  end

  assert_shl_out_R6: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd4) |=> (carry_flag == $past(op_a[W-1])));

  assert_shr_out_R7: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd5) |=> (carry_flag == $past(op_a[0])));

  assert_mul_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd6) |=> (result == $past(mul_product) && !carry_flag));

  assert_logic_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (opcode >= 4'd7 && opcode <= 4'd10) |=> (!carry_flag && result[RW-1:W] == '0));

  assert_unused_op_R10: assert property (@(posedge clk) disable iff (rst)
    (opcode > 4'd10) |=> (result == '0 && !carry_flag && zero_flag));

  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (rst)
    zero_flag == (result == '0));

endmodule

// File: tb/sim_alu16_csa.sv
`timescale 1ns/1ps
module sim_alu16_csa;

  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0;
  logic [3:0]  op = '0;
  logic [31:0] p = '0;
  logic [31:0] result;
  logic        carry_flag, zero_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  alu16_csa u0 (
    .clk         (clk),
    .rst         (rst),
    .op_a        (a),
    .op_b        (b),
    .opcode      (op),
    .mul_product (p),
    .result      (result),
    .carry_flag  (carry_flag),
    .zero_flag   (zero_flag)
  );

  // returns {zero, carry, result}
  function automatic logic [33:0] model(input logic [3:0] o, input logic [15:0] x,
                                        input logic [15:0] y, input logic [31:0] pr);
    logic [16:0] t;
    logic [31:0] r;
    logic        c;
    r = '0; c = 1'b0;
    case (o)
      4'd0: begin t = {1'b0, x} + {1'b0, y};          r = {16'h0, t[15:0]}; c = t[16]; end
      4'd1: begin t = {1'b0, x} + {1'b0, ~y} + 17'd1; r = {16'h0, t[15:0]}; c = t[16]; end
      4'd2: begin t = {1'b0, x} + 17'd1;              r = {16'h0, t[15:0]}; c = t[16]; end
      4'd3: begin t = {1'b0, x} + 17'h0FFFF;          r = {16'h0, t[15:0]}; c = t[16]; end
      4'd4: begin r = {16'h0, x[14:0], 1'b0}; c = x[15]; end
      4'd5: begin r = {17'h0, x[15:1]};       c = x[0];  end
      4'd6: r = pr;
      4'd7: r = {16'h0, x & y};
      4'd8: r = {16'h0, x | y};
      4'd9: r = {16'h0, ~x};
      4'd10: r = {16'h0, x ^ y};
      default: r = '0;
    endcase
    return {(r == 32'h0), c, r};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2 R12";
      4'd1: return "R3 R12";
      4'd2: return "R4 R12";
      4'd3: return "R5 R12";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6: return "R8";
      4'd7, 4'd8, 4'd9, 4'd10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [15:0] x,
                       input logic [15:0] y, input logic [31:0] pr);
    logic [33:0] e;
    @(negedge clk);
    op = o; a = x; b = y; p = pr;
    e = model(o, x, y, pr);
    @(negedge clk);   // one rising edge has registered the operation
    checks++;
    if ({carry_flag, result} !== e[32:0]) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h: got c=%b r=%h exp c=%b r=%h",
               tag_of(o), o, x, y, carry_flag, result, e[32], e[31:0]);
    end
    checks++;
    if (zero_flag !== e[33]) begin
      fails++;
      $display("FAIL R11 op=%0d a=%h b=%h: got z=%b exp z=%b", o, x, y, zero_flag, e[33]);
    end
  endtask

  task automatic check_reset();
    checks++;
    if (result !== 32'h0 || carry_flag !== 1'b0 || zero_flag !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: got r=%h c=%b z=%b exp r=0 c=0 z=1",
               result, carry_flag, zero_flag);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_reset();                       // R1
    rst = 1'b0;

    apply(4'd0, 16'hFFFF, 16'h0001, 32'h0);    // R2 carry out, zero result
    apply(4'd0, 16'h1234, 16'h4321, 32'h0);    // R2
    apply(4'd0, 16'h8000, 16'h8000, 32'h0);    // R2
    apply(4'd1, 16'h0005, 16'h0005, 32'h0);    // R3 equal -> zero, carry 1
    apply(4'd1, 16'h0003, 16'h0007, 32'h0);    // R3 borrow
    apply(4'd1, 16'h0000, 16'h0000, 32'h0);    // R3
    apply(4'd2, 16'hFFFF, 16'h0000, 32'h0);    // R4 wrap
    apply(4'd2, 16'h00FF, 16'hABCD, 32'h0);    // R4
    apply(4'd3, 16'h0000, 16'h1111, 32'h0);    // R5 underflow
    apply(4'd3, 16'h0001, 16'h0000, 32'h0);    // R5 to zero
    apply(4'd4, 16'h8001, 16'h0000, 32'h0);    // R6
    apply(4'd5, 16'h8001, 16'h0000, 32'h0);    // R7
    apply(4'd5, 16'h0001, 16'h0000, 32'h0);    // R7 zero result, carry 1
    apply(4'd6, 16'hFFFF, 16'hFFFF, 32'hDEADBEEF); // R8
    apply(4'd6, 16'h0000, 16'h0000, 32'h0);    // R8 zero
    apply(4'd7, 16'hF0F0, 16'h0FF0, 32'h0);    // R9
    apply(4'd8, 16'hF000, 16'h000F, 32'h0);    // R9
    apply(4'd9, 16'hFFFF, 16'h0000, 32'h0);    // R9 zero
    apply(4'd10, 16'hAAAA, 16'hAAAA, 32'h0);   // R9 zero
    apply(4'd11, 16'hFFFF, 16'hFFFF, 32'hFFFFFFFF); // R10
    apply(4'd15, 16'h8000, 16'h0001, 32'h1);   // R10

    for (int i = 0; i < 800; i++) begin
      logic [3:0] ro;
      logic [15:0] ra, rb;
      ro = 4'($urandom_range(0, 15));
      ra = 16'($urandom());
      rb = 16'($urandom());
      if (($urandom() & 7) == 0) ra = 16'hFFFF;
      if (($urandom() & 7) == 0) rb = ra;
      apply(ro, ra, rb, $urandom());
    end

    // R1: reset mid-run overrides pending operation
    @(negedge clk);
    op = 4'd0; a = 16'h1234; b = 16'h1111; rst = 1'b1;
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    apply(4'd1, 16'h0001, 16'h0002, 32'h0);    // R3 after reset

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule